// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Aligner

This block sits between instruction fetch and the decoders of a wide front end whose instruction set mixes 16-bit and 32-bit instructions. Each cycle it is offered one fetch block. The block is an aligned row of 16-bit parcels, together with the PC of its first parcel. Every parcel gets its own small length check. A chain of instruction starts is then resolved from the current entry point. The first complete instructions are gathered, in program order, into a fixed number of output slots. Each slot carries the instruction word, a size bit, a valid bit and the PC.

A redirect comes in on the flush input with a byte offset into the next block. The offset need not be a multiple of four, so decoding can begin on any 16-bit parcel. An odd offset is refused and raises a misalignment error. A 32-bit instruction that begins in the last parcel of a block is held back and joined with the first parcel of the following block. When a block holds more instructions than there are slots, the rest are issued in later cycles, and the input stays unaccepted until the block is used up. Back-pressure from the decoders freezes the output register.

Top module: `vlen_aligner`

## Requirements
- R1: A start parcel whose two lowest bits are 2'b11 begins a 32-bit instruction: the slot's word holds the next parcel in bits 31:16 and the start parcel in bits 15:0, and its size bit is 1. Any other value of those two bits gives a 16-bit instruction: bits 31:16 are zero and the size bit is 0.
- R2: After a flush with even byte offset k, decoding of the next block starts at parcel k/2. Parcels below it produce no instruction.
- R3: Instructions leave in program order. Valid slots are contiguous from slot 0. The upper half of a 32-bit instruction is never taken as a start.
- R4: At most NSLOT instructions leave per cycle. Any remainder of the block leaves in later cycles. in_ready is high only in the cycle in which the block is fully consumed. No instruction is lost or duplicated.
- R5: A 32-bit instruction that starts in the last parcel is emitted in the cycle that consumes the next block. It takes slot 0, its upper half is that block's parcel 0, and its PC is that of the held parcel.
- R6: A slot's PC is in_pc plus twice the index of its start parcel. Each valid slot after slot 0 has PC equal to the previous slot's PC plus 2 or 4, according to that slot's size.
- R7: A flush clears all output valid bits on the next cycle and discards any held half instruction.
- R8: A flush with an odd offset sets err_misalign on the next cycle. While it is set, no slot is valid, and offered blocks are accepted and discarded. A flush with an even offset clears it.
- R9: While any slot is valid and out_ready is low, the outputs hold their values.
- R10: Slots decoded from a block appear on the cycle after the clock edge at which they are computed. After reset no slot is valid and err_misalign is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Redirect: clear state and load a new entry offset |
| flush_off | input | $clog2(2*NPARC) | Byte offset of the entry point in the next block |
| in_valid | input | 1 | Fetch block present |
| in_data | input | NPARC*16 | Fetch block, parcel 0 in the low bits |
| in_pc | input | PCW | PC of parcel 0 |
| in_ready | output | 1 | Block fully consumed at this edge |
| out_ready | input | 1 | Decoders take the slots at this edge |
| out_valid | output | NSLOT | Per-slot valid |
| out_is32 | output | NSLOT | Per-slot size bit (1 = 32-bit) |
| out_insn | output | NSLOT*32 | Per-slot instruction word |
| out_pc | output | NSLOT*PCW | Per-slot PC |
| err_misalign | output | 1 | Odd entry offset was requested |

## Verification
The bench builds the aligner with eight parcels per block and three slots. With those sizes a block of short instructions overflows the slots, so the multi-cycle drain and the hold on in_ready happen in almost every block. A 32-bit start in the last parcel also comes up often. Random 32-bit/16-bit mixes, random even entry offsets and a randomly stalled out_ready are compared against a sequential walk over the same parcel stream. Directed blocks cover the odd-offset refusal and the latency.

// File: rtl/vla_pkg.sv
package vla_pkg;
   localparam int PARCEL_W = 16;
   localparam int WORD_W   = 32;

   // Length rule: two low bits both set mark a 32-bit instruction.
   function automatic logic parcel_is_long(input logic [PARCEL_W-1:0] p);
      return p[1:0] == 2'b11;
   endfunction
endpackage

// File: rtl/vla_lencheck.sv
module vla_lencheck #(
   parameter int NPARC = 20
) (
   input  logic [NPARC*vla_pkg::PARCEL_W-1:0] parcels,
   output logic [NPARC-1:0]                   long_mask
);
   localparam int PW = vla_pkg::PARCEL_W;

   // One tiny checker per parcel, all in parallel.
   for (genvar g = 0; g < NPARC; g++) begin : g_chk
      assign long_mask[g] = vla_pkg::parcel_is_long(parcels[g*PW +: PW]);
   end
endmodule

// File: rtl/vla_startwalk.sv
module vla_startwalk #(
   parameter int NPARC = 20,
   parameter int POSW  = 5
) (
   input  logic [NPARC-1:0] long_mask,
   input  logic [POSW-1:0]  begin_idx,
   output logic [NPARC-1:0] start_mask
);
   int nxt;

   // Forward walk: a parcel is a start only if the previous start lands on it.
   always_comb begin
      nxt        = int'(begin_idx);
      start_mask = '0;
      for (int i = 0; i < NPARC; i++) begin
         if (i == nxt) begin
            start_mask[i] = 1'b1;
            nxt           = i + (long_mask[i] ? 2 : 1);
         end
      end
   end
endmodule

// File: rtl/vla_gather.sv
module vla_gather #(
   parameter int NPARC = 20,
   parameter int NSLOT = 10,
   parameter int PCW   = 32,
   parameter int POSW  = 5
) (
   input  logic [NPARC*vla_pkg::PARCEL_W-1:0]   parcels,
   input  logic [NPARC-1:0]                     long_mask,
   input  logic [NPARC-1:0]                     start_mask,
   input  logic                                 hold_valid,
   input  logic [vla_pkg::PARCEL_W-1:0]         hold_parcel,
   input  logic [PCW-1:0]                       hold_pc,
   input  logic [PCW-1:0]                       base_pc,
   output logic [NSLOT-1:0][vla_pkg::WORD_W-1:0] slot_word,
   output logic [NSLOT-1:0]                     slot_long,
   output logic [NSLOT-1:0][PCW-1:0]            slot_pc,
   output logic [NSLOT-1:0]                     slot_valid,
   output logic                                 all_done,
   output logic [POSW-1:0]                      next_pos,
   output logic                                 tail_hold
);
   localparam int PW = vla_pkg::PARCEL_W;

   logic [(NPARC+1)*PW-1:0] ext;
   int                      cnt;

   assign ext = {{PW{1'b0}}, parcels};

   always_comb begin
      slot_word  = '0;
      slot_long  = '0;
      slot_pc    = '0;
      slot_valid = '0;
      all_done   = 1'b1;
      next_pos   = '0;
      tail_hold  = 1'b0;
      cnt        = 0;
      // A held lower half completes with parcel 0 and takes slot 0.
      if (hold_valid) begin
         slot_word[0]  = {parcels[PW-1:0], hold_parcel};
         slot_long[0]  = 1'b1;
         slot_pc[0]    = hold_pc;
         slot_valid[0] = 1'b1;
         cnt           = 1;
      end
      for (int i = 0; i < NPARC; i++) begin
         if (all_done && start_mask[i]) begin
            if (cnt == NSLOT) begin
               all_done = 1'b0;
               next_pos = POSW'(i);
            end else if (long_mask[i] && i == NPARC-1) begin
               tail_hold = 1'b1;
            end else begin
               for (int s = 0; s < NSLOT; s++) begin
                  if (s == cnt) begin
                     slot_valid[s] = 1'b1;
                     slot_long[s]  = long_mask[i];
                     slot_word[s]  = long_mask[i] ?
                        {ext[(i+1)*PW +: PW], ext[i*PW +: PW]} :
                        {{PW{1'b0}}, ext[i*PW +: PW]};
                     slot_pc[s]    = base_pc + PCW'(2*i);
                  end
               end
               cnt = cnt + 1;
            end
         end
      end
   end
endmodule

// File: rtl/vlen_aligner.sv
module vlen_aligner #(
   parameter int NPARC = 20,
   parameter int NSLOT = 10,
   parameter int PCW   = 32
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         flush,
   input  logic [$clog2(2*NPARC)-1:0]   flush_off,
   input  logic                         in_valid,
   input  logic [NPARC*16-1:0]          in_data,
   input  logic [PCW-1:0]               in_pc,
   output logic                         in_ready,
   input  logic                         out_ready,
   output logic [NSLOT-1:0]             out_valid,
   output logic [NSLOT-1:0]             out_is32,
   output logic [NSLOT*32-1:0]          out_insn,
   output logic [NSLOT*PCW-1:0]         out_pc,
   output logic                         err_misalign
);
   localparam int PW   = vla_pkg::PARCEL_W;
   localparam int WW   = vla_pkg::WORD_W;
   localparam int OFFW = $clog2(2*NPARC);
   localparam int POSW = OFFW - 1;

   if (NPARC < 2) begin : g_bad_parc
      $error("vlen_aligner: NPARC must be at least 2");
   end
   if (NSLOT < 1 || NSLOT > NPARC) begin : g_bad_slot
      $error("vlen_aligner: NSLOT must lie in 1..NPARC");
   end
   if (PCW < 2) begin : g_bad_pcw
      $error("vlen_aligner: PCW must be at least 2");
   end

   // State
   logic [POSW-1:0]            pos_q;
   logic                       hold_v_q;
   logic [PW-1:0]              hold_par_q;
   logic [PCW-1:0]             hold_pc_q;
   logic                       err_q;
   logic [NSLOT-1:0]           val_q;
   logic [NSLOT-1:0]           long_q;
   logic [NSLOT-1:0][WW-1:0]   word_q;
   logic [NSLOT-1:0][PCW-1:0]  pc_q;

   // Datapath
   logic [NPARC-1:0]           long_mask;
   logic [NPARC-1:0]           start_mask;
   logic [POSW-1:0]            begin_idx;
   logic [NSLOT-1:0][WW-1:0]   g_word;
   logic [NSLOT-1:0]           g_long;
   logic [NSLOT-1:0][PCW-1:0]  g_pc;
   logic [NSLOT-1:0]           g_valid;
   logic                       g_done;
   logic [POSW-1:0]            g_next;
   logic                       g_tail;
   logic                       load;

   assign begin_idx = hold_v_q ? POSW'(1) : pos_q;

   vla_lencheck #(.NPARC(NPARC)) u_len (
      .parcels   (in_data),
      .long_mask (long_mask)
   );

   vla_startwalk #(.NPARC(NPARC), .POSW(POSW)) u_walk (
      .long_mask  (long_mask),
      .begin_idx  (begin_idx),
      .start_mask (start_mask)
   );

   vla_gather #(.NPARC(NPARC), .NSLOT(NSLOT), .PCW(PCW), .POSW(POSW)) u_gath (
      .parcels     (in_data),
      .long_mask   (long_mask),
      .start_mask  (start_mask),
      .hold_valid  (hold_v_q),
      .hold_parcel (hold_par_q),
      .hold_pc     (hold_pc_q),
      .base_pc     (in_pc),
      .slot_word   (g_word),
      .slot_long   (g_long),
      .slot_pc     (g_pc),
      .slot_valid  (g_valid),
      .all_done    (g_done),
      .next_pos    (g_next),
      .tail_hold   (g_tail)
   );

   // Output register may take new slots when empty or being drained.
   assign load     = out_ready || !(|val_q);
   assign in_ready = !flush && (err_q || (load && g_done));

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q      <= '0;
         hold_v_q   <= 1'b0;
         hold_par_q <= '0;
         hold_pc_q  <= '0;
         err_q      <= 1'b0;
         val_q      <= '0;
         long_q     <= '0;
         word_q     <= '0;
         pc_q       <= '0;
      end else if (flush) begin
         val_q    <= '0;
         hold_v_q <= 1'b0;
         pos_q    <= flush_off[OFFW-1:1];
         err_q    <= flush_off[0];
      end else if (load) begin
         if (in_valid && !err_q) begin
            val_q  <= g_valid;
            long_q <= g_long;
            word_q <= g_word;
            pc_q   <= g_pc;
            if (g_done) begin
               pos_q      <= '0;
               hold_v_q   <= g_tail;
               hold_par_q <= in_data[(NPARC-1)*PW +: PW];
               hold_pc_q  <= in_pc + PCW'(2*(NPARC-1));
            end else begin
               pos_q    <= g_next;
               hold_v_q <= 1'b0;
            end
         end else begin
            val_q <= '0;
         end
      end
   end

   assign out_valid    = val_q;
   assign out_is32     = long_q;
   assign out_insn     = word_q;
   assign out_pc       = pc_q;
   assign err_misalign = err_q;
endmodule

// File: rtl/vla_checker.sv
module vla_checker #(
   parameter int NPARC = 20,
   parameter int NSLOT = 10,
   parameter int PCW   = 32
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       flush,
   input logic [$clog2(2*NPARC)-1:0] flush_off,
   input logic                       out_ready,
   input logic [NSLOT-1:0]           out_valid,
   input logic [NSLOT-1:0]           out_is32,
   input logic [NSLOT*32-1:0]        out_insn,
   input logic [NSLOT*PCW-1:0]       out_pc,
   input logic                       err_misalign
);
   assert_contig_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid & (out_valid + NSLOT'(1))) == '0);

   assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
      (|out_valid && !out_ready && !flush) |=>
         ($stable(out_valid) && $stable(out_insn) && $stable(out_pc) && $stable(out_is32)));

   assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
      flush |=> out_valid == '0);

   assert_odd_sets_R8: assert property (@(posedge clk) disable iff (rst)
      (flush && flush_off[0]) |=> err_misalign);

   assert_even_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (flush && !flush_off[0]) |=> !err_misalign);

   assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      err_misalign |-> out_valid == '0);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assert_size_R1: assert property (@(posedge clk) disable iff (rst)
         out_valid[s] |->
            (out_is32[s] ? (out_insn[s*32 +: 2] == 2'b11)
                         : (out_insn[s*32 +: 2] != 2'b11 && out_insn[s*32+16 +: 16] == 16'h0)));
      if (s > 0) begin : g_step
         assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
            out_valid[s] |->
               out_pc[s*PCW +: PCW] == out_pc[(s-1)*PCW +: PCW] + (out_is32[s-1] ? PCW'(4) : PCW'(2)));
      end
   end
endmodule

bind vlen_aligner vla_checker #(.NPARC(NPARC), .NSLOT(NSLOT), .PCW(PCW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .flush        (flush),
   .flush_off    (flush_off),
   .out_ready    (out_ready),
   .out_valid    (out_valid),
   .out_is32     (out_is32),
   .out_insn     (out_insn),
   .out_pc       (out_pc),
   .err_misalign (err_misalign)
);

// File: tb/sim_vlen_aligner.sv
module sim_vlen_aligner;
   localparam int NP   = 8;
   localparam int NS   = 3;
   localparam int PCW  = 32;
   localparam int OFFW = $clog2(2*NP);

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic               flush = 1'b0;
   logic [OFFW-1:0]    flush_off = '0;
   logic               in_valid = 1'b0;
   logic [NP*16-1:0]   in_data = '0;
   logic [PCW-1:0]     in_pc = '0;
   logic               in_ready;
   logic               out_ready = 1'b0;
   logic [NS-1:0]      out_valid;
   logic [NS-1:0]      out_is32;
   logic [NS*32-1:0]   out_insn;
   logic [NS*PCW-1:0]  out_pc;
   logic               err_misalign;

   vlen_aligner #(.NPARC(NP), .NSLOT(NS), .PCW(PCW)) u0 (
      .clk(clk), .rst(rst), .flush(flush), .flush_off(flush_off),
      .in_valid(in_valid), .in_data(in_data), .in_pc(in_pc), .in_ready(in_ready),
      .out_ready(out_ready), .out_valid(out_valid), .out_is32(out_is32),
      .out_insn(out_insn), .out_pc(out_pc), .err_misalign(err_misalign)
   );

   typedef struct packed {
      logic [31:0]    w;
      logic           l;
      logic [PCW-1:0] pc;
   } exp_t;

   exp_t           q[$];
   int             n_cmp = 0;
   int             n_bad = 0;
   bit             rdy_all = 1'b0;
   bit             chk_lat = 1'b0;
   logic [PCW-1:0] lat_pc;
   int             m_pos = 0;
   bit             m_hv = 1'b0;
   logic [15:0]    m_hp;
   logic [PCW-1:0] m_hpc;
   logic [PCW-1:0] pcb = 32'h0000_4000;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rparc();
      logic [15:0] v;
      v = 16'($urandom);
      if ($urandom_range(1) == 1) v[1:0] = 2'b11;
      else v[1:0] = 2'($urandom_range(2));
      return v;
   endfunction

   function automatic logic [NP*16-1:0] rblock();
      logic [NP*16-1:0] d;
      for (int i = 0; i < NP; i++) d[i*16 +: 16] = rparc();
      return d;
   endfunction

   // Monitor: outputs sampled now move at the coming edge when out_ready is high.
   task automatic monitor();
      if (chk_lat) begin
         check(out_valid == {NS{1'b1}}, "R10", "slots one cycle after block", 64'(out_valid), 64'({NS{1'b1}}));
         check(out_pc[PCW-1:0] == lat_pc, "R10", "first slot pc", 64'(out_pc[PCW-1:0]), 64'(lat_pc));
         chk_lat = 1'b0;
      end
      if (out_ready) begin
         for (int s = 0; s < NS; s++) begin
            if (out_valid[s]) begin
               if (q.size() == 0) begin
                  check(1'b0, "R4", "slot with nothing expected", 64'(s), 64'(0));
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(out_insn[s*32 +: 32] == e.w, "R1 R3 R5", "slot word", 64'(out_insn[s*32 +: 32]), 64'(e.w));
                  check(out_is32[s] == e.l, "R1", "slot size", 64'(out_is32[s]), 64'(e.l));
                  check(out_pc[s*PCW +: PCW] == e.pc, "R2 R6", "slot pc", 64'(out_pc[s*PCW +: PCW]), 64'(e.pc));
               end
            end
         end
      end
   endtask

   task automatic step();
      @(negedge clk);
      out_ready = rdy_all ? 1'b1 : ($urandom_range(3) != 0);
      #1;
      monitor();
   endtask

   // Sequential reference walk over one block.
   task automatic model_block(input logic [NP*16-1:0] d, input logic [PCW-1:0] pc);
      int i;
      logic [15:0] p;
      i = m_pos;
      if (m_hv) begin
         q.push_back('{w: {d[15:0], m_hp}, l: 1'b1, pc: m_hpc});
         m_hv = 1'b0;
         i = 1;
      end
      while (i < NP) begin
         p = d[i*16 +: 16];
         if (p[1:0] == 2'b11) begin
            if (i == NP-1) begin
               m_hv = 1'b1; m_hp = p; m_hpc = pc + PCW'(2*i);
               i++;
            end else begin
               q.push_back('{w: {d[(i+1)*16 +: 16], p}, l: 1'b1, pc: pc + PCW'(2*i)});
               i += 2;
            end
         end else begin
            q.push_back('{w: {16'h0, p}, l: 1'b0, pc: pc + PCW'(2*i)});
            i++;
         end
      end
      m_pos = 0;
   endtask

   task automatic send_block(input logic [NP*16-1:0] d, input logic [PCW-1:0] pc);
      bit acc;
      int guard;
      model_block(d, pc);
      in_valid = 1'b1; in_data = d; in_pc = pc;
      guard = 0;
      forever begin
         #1;
         acc = in_ready;
         step();
         if (acc) break;
         guard++;
         if (guard > 60) begin
            check(1'b0, "R4", "block never accepted", 64'(guard), 64'(0));
            break;
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic do_flush(input int off);
      in_valid = 1'b0;
      flush = 1'b1;
      flush_off = OFFW'(off);
      #1;
      step();
      flush = 1'b0;
      check(out_valid == '0, "R7", "outputs after flush", 64'(out_valid), 64'(0));
      q.delete();
      m_pos = off / 2;
      m_hv = 1'b0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      check(1'b0, "R4", "watchdog expired", 64'(0), 64'(1));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : driver
      logic [NP*16-1:0] d;
      repeat (3) @(negedge clk);
      check(out_valid == '0, "R10", "reset valid", 64'(out_valid), 64'(0));
      check(err_misalign == 1'b0, "R10", "reset error", 64'(err_misalign), 64'(0));
      rst = 1'b0;

      // Latency and overflow into later cycles
      rdy_all = 1'b1;
      do_flush(0);
      d = '0;
      for (int i = 0; i < NP; i++) d[i*16 +: 16] = 16'h1000 + 16'(i*16);
      chk_lat = 1'b1;
      lat_pc = pcb;
      send_block(d, pcb); pcb += PCW'(2*NP);

      // Tail held and joined (R5)
      for (int i = 0; i < NP; i++) d[i*16 +: 16] = 16'h2200 + 16'(i*4);
      d[(NP-1)*16 +: 16] = 16'hBEE3;
      send_block(d, pcb); pcb += PCW'(2*NP);
      d = rblock();
      d[15:0] = 16'hCAFE;
      send_block(d, pcb); pcb += PCW'(2*NP);

      // Unaligned-to-32 entry point (R2)
      do_flush(6);
      send_block(rblock(), pcb); pcb += PCW'(2*NP);

      // Odd entry offset (R8)
      do_flush(5);
      check(err_misalign == 1'b1, "R8", "error after odd offset", 64'(err_misalign), 64'(1));
      in_valid = 1'b1; in_data = rblock(); in_pc = pcb;
      #1;
      check(in_ready == 1'b1, "R8", "block discarded while in error", 64'(in_ready), 64'(1));
      step();
      in_valid = 1'b0;
      check(out_valid == '0, "R8", "no slots while in error", 64'(out_valid), 64'(0));
      do_flush(0);
      check(err_misalign == 1'b0, "R8", "error cleared", 64'(err_misalign), 64'(0));
      pcb += PCW'(2*NP);

      // Random stream with stalls and redirects
      rdy_all = 1'b0;
      for (int b = 0; b < 400; b++) begin
         if (b % 37 == 36) do_flush(2 * $urandom_range(NP-1));
         send_block(rblock(), pcb);
         pcb += PCW'(2*NP);
      end

      rdy_all = 1'b1;
      repeat (4) step();
      check(q.size() == 0, "R4 R9", "items left undelivered", 64'(q.size()), 64'(0));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule